// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block brings a two-bank SDR SDRAM out of power-up. It drives the memory's control pins from reset until the device can take normal traffic. Through a timed stabilization wait it keeps clock enable and the data mask high and presents command-inhibit. It then issues a precharge that closes both banks and programs the device. Programming is a run of auto-refresh commands plus one mode-register load. The load carries burst length, burst ordering, read latency and write mode on the address bus. It ends by raising a ready flag that a memory controller uses to take over the command bus.

The gaps between commands are parameters in clock cycles: the stabilization wait, precharge recovery, refresh recovery and the guard after the mode-register load. The refresh count is also a parameter. A configuration input selects whether the mode-register load comes before or after the refresh run. The configuration inputs are captured throughout the stabilization wait and are frozen once the first command goes out, so the device always sees one consistent setting.

Top module: `sdram_init_seq`

## Requirements
- R1: `sd_cke` and `sd_dqm` are high while reset is applied and in every cycle after it.
- R2: During reset and for STABLE_CYC cycles after reset is released, the pins carry command-inhibit (`sd_cs_n` high). The first command, a precharge, appears in cycle STABLE_CYC+1, counting the first clock edge with reset high as cycle 1.
- R3: The precharge is encoded {cs_n,ras_n,cas_n,we_n} = 0010, with address bit 10 high and every other address bit low, so that both banks close.
- R4: Exactly REF_CNT auto-refresh commands (0001) are issued, with REF_CNT at least 2. The command after the precharge comes TRP_CYC cycles after it, and the command or ready edge after each refresh comes TRFC_CYC cycles after it.
- R5: The mode-register load (0000) carries the mode word: bits 2..0 burst length, bit 3 burst ordering, bits 6..4 read latency, bit 9 write mode (0 = burst write, 1 = single write). Bits 8, 7, 11 and 10 and all higher bits are 0.
- R6: The mode-register load is issued only while both banks are idle: at least TRP_CYC cycles after the precharge and at least TRFC_CYC cycles after any refresh.
- R7: After the mode-register load, the next command or the ready edge follows exactly MRD_CYC cycles later, and MRD_CYC is at least 2.
- R8: With `cfg_mrs_first` = 0 the order is precharge, refreshes, mode load. With `cfg_mrs_first` = 1 it is precharge, mode load, refreshes.
- R9: The configuration inputs are sampled only during the stabilization wait. Changes after the first command alter neither the mode word nor the order.
- R10: `init_done` rises exactly one guard interval after the last command and stays high until reset. In every cycle after the wait that is not a command cycle, the pins carry NOP (0111).
- R11: Reset applied in the middle of the sequence drops `init_done`, returns the pins to command-inhibit, and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mrs_first | input | 1 | 1: mode load before the refreshes |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_seq | input | 1 | Burst ordering (0 sequential, 1 interleaved) |
| cfg_cas_lat | input | 3 | Read latency code |
| cfg_single_write | input | 1 | 1: single write, 0: burst write |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |

## Verification
The sequence is run in both orderings with different mode-word settings. Comparing the orderings shows whether the order select is honoured. It also shows that each gap follows the command before it and not a fixed slot position. Two sets of mode fields with complementary bit values catch swapped or misplaced fields on the address bus. A run that changes every configuration input right after the precharge separates capture during the wait from live use of the inputs. A reset in the middle of a sequence, followed by a full run, shows that the state is fully cleared.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
// Package: command and state types shared by the initialization sequencer.
// Assumes the usual SDR command truth table on {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_INHIBIT,
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } cmd_e;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_PRE,
        ST_REF,
        ST_MRS,
        ST_GAP,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    // Map an abstract command onto the four strobe pins.
    function automatic pins_t encode_cmd(cmd_e c);
        pins_t p;
        unique case (c)
            CMD_NOP: p = 4'b0111;
            CMD_PRE: p = 4'b0010;
            CMD_REF: p = 4'b0001;
            CMD_MRS: p = 4'b0000;
            default: p = 4'b1111;
        endcase
        return p;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_cycle_timer.sv
`timescale 1ns/1ps
// Down-counter used for every wait of the sequence.
// It loads on request, otherwise counts down to zero and holds there.
// Reset loads RST_VAL so that the stabilization wait starts with no extra cycle.
module init_cycle_timer #(
    parameter int unsigned    W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count register: reset value, reload, or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/init_mode_word.sv
`timescale 1ns/1ps
// Captures the configuration inputs while `capture` is high and builds the
// mode word from the captured copy. Assumes ADDR_W >= 12; unused bits are 0.
module init_mode_word #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              mrs_first_in,
    input  logic [2:0]        burst_len_in,
    input  logic              burst_seq_in,
    input  logic [2:0]        cas_lat_in,
    input  logic              single_write_in,
    output logic              mrs_first_q,
    output logic [ADDR_W-1:0] mode_word
);

    logic [2:0] burst_len_q;
    logic       burst_seq_q;
    logic [2:0] cas_lat_q;
    logic       single_write_q;

    // Capture registers: follow the inputs during reset and the wait, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n || capture) begin
            mrs_first_q    <= mrs_first_in;
            burst_len_q    <= burst_len_in;
            burst_seq_q    <= burst_seq_in;
            cas_lat_q      <= cas_lat_in;
            single_write_q <= single_write_in;
        end
    end

    // Field placement of the mode word; the device decodes these positions.
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = burst_len_q;
        mode_word[3]   = burst_seq_q;
        mode_word[6:4] = cas_lat_q;
        mode_word[9]   = single_write_q;
    end

endmodule

// File: rtl/init_phase_ctrl.sv
`timescale 1ns/1ps
// Phase controller of the power-on sequence. Each command state lasts one
// cycle and is followed by a gap state timed by the shared down-counter.
// The command after a gap depends on the last command, on the refresh count
// and on the order select. Assumes all gaps >= 2 and REF_CNT >= 2.
module init_phase_ctrl
    import sdram_init_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 10000,
    parameter int unsigned TRP_CYC    = 3,
    parameter int unsigned TRFC_CYC   = 7,
    parameter int unsigned MRD_CYC    = 2,
    parameter int unsigned REF_CNT    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mrs_first,
    output cmd_e cmd,
    output logic capture,
    output logic done
);

    localparam int unsigned MAX_WAIT = max_u(max_u(STABLE_CYC, TRP_CYC), max_u(TRFC_CYC, MRD_CYC));
    localparam int unsigned TMR_W    = $clog2(MAX_WAIT + 1);
    localparam int unsigned REF_W    = $clog2(REF_CNT + 1);
    localparam logic [TMR_W-1:0] WAIT_LD = TMR_W'(STABLE_CYC - 1);
    localparam logic [TMR_W-1:0] TRP_LD  = TMR_W'(TRP_CYC - 2);
    localparam logic [TMR_W-1:0] TRFC_LD = TMR_W'(TRFC_CYC - 2);
    localparam logic [TMR_W-1:0] MRD_LD  = TMR_W'(MRD_CYC - 2);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_CNT);

    state_e             state, state_nx;
    cmd_e               last_cmd;
    logic [REF_W-1:0]   ref_cnt;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_zero;

    init_cycle_timer #(
        .W       (TMR_W),
        .RST_VAL (WAIT_LD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Next-state and timer-load decision for the current phase.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_WAIT: if (tmr_zero) state_nx = ST_PRE;
            ST_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = TRP_LD;
                state_nx = ST_GAP;
            end
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = TRFC_LD;
                state_nx = ST_GAP;
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = MRD_LD;
                state_nx = ST_GAP;
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    unique case (last_cmd)
                        CMD_PRE: state_nx = mrs_first ? ST_MRS : ST_REF;
                        CMD_MRS: state_nx = mrs_first ? ST_REF : ST_DONE;
                        default: begin
                            if (ref_cnt < REF_LAST)
                                state_nx = ST_REF;
                            else
                                state_nx = mrs_first ? ST_DONE : ST_MRS;
                        end
                    endcase
                end
            end
            default: state_nx = ST_DONE;
        endcase
    end

    // Phase register, last issued command and refresh tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT;
            last_cmd <= CMD_INHIBIT;
            ref_cnt  <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_PRE: last_cmd <= CMD_PRE;
                ST_MRS: last_cmd <= CMD_MRS;
                ST_REF: begin
                    last_cmd <= CMD_REF;
                    ref_cnt  <= ref_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Command requested in the current phase.
    always_comb begin
        unique case (state)
            ST_WAIT: cmd = CMD_INHIBIT;
            ST_PRE:  cmd = CMD_PRE;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    assign capture = (state == ST_WAIT);
    assign done    = (state == ST_DONE);

endmodule

// File: rtl/init_pin_drive.sv
`timescale 1ns/1ps
// Output register stage: turns the abstract command into pin levels and
// address, so all pins leave flops together. One cycle of latency applies
// equally to commands and ready, so the spacing is unchanged.
module init_pin_drive
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] mode_word,
    input  logic              done,
    output logic              cke,
    output logic              dqm,
    output pins_t             pins,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);

    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    logic [ADDR_W-1:0] addr_nx;

    // Address source for the command being issued.
    always_comb begin
        unique case (cmd)
            CMD_PRE: addr_nx = ALL_BANKS;
            CMD_MRS: addr_nx = mode_word;
            default: addr_nx = '0;
        endcase
    end

    // Pin registers; reset presents command-inhibit with clock enable and mask high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke   <= 1'b1;
            dqm   <= 1'b1;
            pins  <= encode_cmd(CMD_INHIBIT);
            addr  <= '0;
            ready <= 1'b0;
        end else begin
            cke   <= 1'b1;
            dqm   <= 1'b1;
            pins  <= encode_cmd(cmd);
            addr  <= addr_nx;
            ready <= done;
        end
    end

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
// Top of the SDRAM power-on initialization sequencer.
// Assumes STABLE_CYC >= 1, TRP_CYC/TRFC_CYC/MRD_CYC >= 2, REF_CNT >= 2 and
// ADDR_W >= 12. Configuration is taken during the stabilization wait only.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned STABLE_CYC = 10000,
    parameter int unsigned TRP_CYC    = 3,
    parameter int unsigned TRFC_CYC   = 7,
    parameter int unsigned MRD_CYC    = 2,
    parameter int unsigned REF_CNT    = 2,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mrs_first,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_seq,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_single_write,
    output logic              sd_cke,
    output logic              sd_dqm,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              init_done
);

    cmd_e              cmd;
    logic              capture;
    logic              done;
    logic              mrs_first_q;
    logic [ADDR_W-1:0] mode_word;
    pins_t             pins;

    init_mode_word #(
        .ADDR_W (ADDR_W)
    ) u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .capture         (capture),
        .mrs_first_in    (cfg_mrs_first),
        .burst_len_in    (cfg_burst_len),
        .burst_seq_in    (cfg_burst_seq),
        .cas_lat_in      (cfg_cas_lat),
        .single_write_in (cfg_single_write),
        .mrs_first_q     (mrs_first_q),
        .mode_word       (mode_word)
    );

    init_phase_ctrl #(
        .STABLE_CYC (STABLE_CYC),
        .TRP_CYC    (TRP_CYC),
        .TRFC_CYC   (TRFC_CYC),
        .MRD_CYC    (MRD_CYC),
        .REF_CNT    (REF_CNT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrs_first (mrs_first_q),
        .cmd       (cmd),
        .capture   (capture),
        .done      (done)
    );

    init_pin_drive #(
        .ADDR_W (ADDR_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .mode_word (mode_word),
        .done      (done),
        .cke       (sd_cke),
        .dqm       (sd_dqm),
        .pins      (pins),
        .addr      (sd_addr),
        .ready     (init_done)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

endmodule

// File: rtl/sdram_init_seq_chk.sv
`timescale 1ns/1ps
// Checker for the initialization sequencer, bound to the top module.
// It keeps its own cycle counters of the distance since each command type
// and since reset, and relates them to the pins.
module sdram_init_seq_chk #(
    parameter int unsigned STABLE_CYC = 10000,
    parameter int unsigned TRP_CYC    = 3,
    parameter int unsigned TRFC_CYC   = 7,
    parameter int unsigned MRD_CYC    = 2,
    parameter int unsigned ADDR_W     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_dqm,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);

    localparam int unsigned GMAX = (TRP_CYC > TRFC_CYC) ?
                                   ((TRP_CYC > MRD_CYC) ? TRP_CYC : MRD_CYC) :
                                   ((TRFC_CYC > MRD_CYC) ? TRFC_CYC : MRD_CYC);
    localparam int unsigned CW   = $clog2(GMAX + 2);
    localparam logic [CW-1:0] CAP = CW'(GMAX + 1);
    localparam int unsigned BW   = $clog2(STABLE_CYC + 2);
    localparam logic [BW-1:0] BOOT_END = BW'(STABLE_CYC + 1);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

    logic [3:0] code;
    logic       is_pre, is_ref, is_mrs, is_nop, is_cmd;
    logic [CW-1:0] since_pre, since_ref, since_mrs;
    logic [BW-1:0] boot_cnt;

    assign code   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_pre = (code == 4'b0010);
    assign is_ref = (code == 4'b0001);
    assign is_mrs = (code == 4'b0000);
    assign is_nop = (code == 4'b0111);
    assign is_cmd = !sd_cs_n && !is_nop;

    // Distance counters since each command type and since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= CAP;
            since_ref <= CAP;
            since_mrs <= CAP;
            boot_cnt  <= '0;
        end else begin
            since_pre <= is_pre ? CW'(1) : ((since_pre != CAP) ? since_pre + 1'b1 : CAP);
            since_ref <= is_ref ? CW'(1) : ((since_ref != CAP) ? since_ref + 1'b1 : CAP);
            since_mrs <= is_mrs ? CW'(1) : ((since_mrs != CAP) ? since_mrs + 1'b1 : CAP);
            if (boot_cnt != BOOT_END)
                boot_cnt <= boot_cnt + 1'b1;
        end
    end

    a_r1_cke_dqm_high: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke && sd_dqm);

    a_r2_inhibit_during_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_cnt <= BW'(STABLE_CYC)) |-> sd_cs_n);

    a_r3_precharge_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (sd_addr == ALL_BANKS));

    a_r4_refresh_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (since_ref >= CW'(TRFC_CYC)) && (since_pre >= CW'(TRP_CYC)));

    a_r6_mrs_banks_idle: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (since_pre >= CW'(TRP_CYC)) && (since_ref >= CW'(TRFC_CYC)));

    a_r7_mrs_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd || init_done) |-> (since_mrs >= CW'(MRD_CYC)));

    a_r10_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r10_ready_nop: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .STABLE_CYC (STABLE_CYC),
    .TRP_CYC    (TRP_CYC),
    .TRFC_CYC   (TRFC_CYC),
    .MRD_CYC    (MRD_CYC),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cke    (sd_cke),
    .sd_dqm    (sd_dqm),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .init_done (init_done)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sdram_init_seq_tb;

    localparam int S    = 20;
    localparam int TRP  = 3;
    localparam int TRFC = 5;
    localparam int MRD  = 2;
    localparam int NREF = 3;
    localparam int AW   = 12;

    localparam logic [3:0] C_INH = 4'b1111;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_mrs_first = 1'b0;
    logic [2:0]    cfg_burst_len = 3'd0;
    logic          cfg_burst_seq = 1'b0;
    logic [2:0]    cfg_cas_lat = 3'd0;
    logic          cfg_single_write = 1'b0;
    logic          sd_cke, sd_dqm, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [AW-1:0] sd_addr;
    logic          init_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int         rec_t [16];
    logic [3:0] rec_c [16];
    logic [AW-1:0] rec_a [16];
    int         n_rec;
    int         ready_t;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .STABLE_CYC (S),
        .TRP_CYC    (TRP),
        .TRFC_CYC   (TRFC),
        .MRD_CYC    (MRD),
        .REF_CNT    (NREF),
        .ADDR_W     (AW)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_mrs_first    (cfg_mrs_first),
        .cfg_burst_len    (cfg_burst_len),
        .cfg_burst_seq    (cfg_burst_seq),
        .cfg_cas_lat      (cfg_cas_lat),
        .cfg_single_write (cfg_single_write),
        .sd_cke           (sd_cke),
        .sd_dqm           (sd_dqm),
        .sd_cs_n          (sd_cs_n),
        .sd_ras_n         (sd_ras_n),
        .sd_cas_n         (sd_cas_n),
        .sd_we_n          (sd_we_n),
        .sd_addr          (sd_addr),
        .init_done        (init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Full run from reset; records every command and the ready cycle.
    task automatic do_run(input bit mf, input logic [2:0] bl, input bit bt,
                          input logic [2:0] cl, input bit wm, input bit chg);
        int cyc, bad_ck, bad_inh, bad_idle, stay;
        bit changed;
        logic [3:0] code;
        rst_n = 1'b0;
        cfg_mrs_first = mf; cfg_burst_len = bl; cfg_burst_seq = bt;
        cfg_cas_lat = cl; cfg_single_write = wm;
        repeat (3) @(negedge clk);
        // R1 R2 R10 reset state
        chk(sd_cke && sd_dqm && sd_cs_n && !init_done, "R2", "reset pin state",
            {sd_cke, sd_dqm, sd_cs_n, init_done}, 4'b1110);
        rst_n = 1'b1;
        cyc = 0; n_rec = 0; ready_t = -1; bad_ck = 0; bad_inh = 0; bad_idle = 0;
        stay = 0; changed = 0;
        while (cyc < 400 && stay < 5) begin
            @(negedge clk);
            cyc++;
            code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!(sd_cke && sd_dqm)) bad_ck++;
            if (cyc <= S && code != C_INH) bad_inh++;
            if (cyc > S && code != C_NOP && code != C_PRE && code != C_REF && code != C_MRS)
                bad_idle++;
            if (code == C_PRE || code == C_REF || code == C_MRS) begin
                if (n_rec < 16) begin
                    rec_t[n_rec] = cyc; rec_c[n_rec] = code; rec_a[n_rec] = sd_addr;
                end
                n_rec++;
            end
            if (init_done) begin
                if (ready_t < 0) ready_t = cyc;
                stay++;
                if (code != C_NOP) bad_idle++;
            end else if (ready_t >= 0) begin
                bad_idle++;
                stay++;
            end
            if (chg && !changed && n_rec >= 1) begin
                cfg_mrs_first = ~mf; cfg_burst_len = ~bl; cfg_burst_seq = ~bt;
                cfg_cas_lat = ~cl; cfg_single_write = ~wm;
                changed = 1;
            end
        end
        chk(bad_ck == 0, "R1", "cycles with cke/dqm low", bad_ck, 0);
        chk(bad_inh == 0, "R2", "non-inhibit cycles in wait", bad_inh, 0);
        chk(bad_idle == 0, "R10", "non-NOP idle or ready drop cycles", bad_idle, 0);
        chk(n_rec == NREF + 2, "R4", "command count", n_rec, NREF + 2);
    endtask

    // Compare the recorded commands against the expected order and timing.
    task automatic compare(input bit mf, input logic [2:0] bl, input bit bt,
                           input logic [2:0] cl, input bit wm, input string tag);
        logic [3:0] ec [16];
        int et [16];
        int k, t;
        logic [AW-1:0] word;
        word = '0;
        word[2:0] = bl; word[3] = bt; word[6:4] = cl; word[9] = wm;
        k = 0; t = S + 1;
        ec[k] = C_PRE; et[k] = t; k++; t += TRP;
        if (mf) begin
            ec[k] = C_MRS; et[k] = t; k++; t += MRD;
        end
        for (int i = 0; i < NREF; i++) begin
            ec[k] = C_REF; et[k] = t; k++; t += TRFC;
        end
        if (!mf) begin
            ec[k] = C_MRS; et[k] = t; k++; t += MRD;
        end
        for (int i = 0; i < k && i < n_rec; i++) begin
            // R8 order, R4 R6 R7 spacing
            chk(rec_c[i] == ec[i], "R8", {tag, " command code"}, rec_c[i], ec[i]);
            chk(rec_t[i] == et[i], "R4", {tag, " command cycle"}, rec_t[i], et[i]);
            if (ec[i] == C_PRE)
                chk(rec_a[i] == 12'h400, "R3", {tag, " precharge addr"}, rec_a[i], 12'h400);
            if (ec[i] == C_MRS)
                chk(rec_a[i] == word, "R5", {tag, " mode word"}, rec_a[i], word);
        end
        chk(ready_t == t, "R7", {tag, " ready cycle"}, ready_t, t);
    endtask

    task automatic t_normal_order();
        do_run(1'b0, 3'b011, 1'b0, 3'b010, 1'b0, 1'b0);
        compare(1'b0, 3'b011, 1'b0, 3'b010, 1'b0, "normal");
    endtask

    task automatic t_mrs_first();
        do_run(1'b1, 3'b100, 1'b1, 3'b101, 1'b1, 1'b0);
        compare(1'b1, 3'b100, 1'b1, 3'b101, 1'b1, "mrs_first");
    endtask

    // R9: inputs flipped after the precharge must not change anything.
    task automatic t_cfg_frozen();
        do_run(1'b0, 3'b001, 1'b1, 3'b011, 1'b1, 1'b1);
        compare(1'b0, 3'b001, 1'b1, 3'b011, 1'b1, "R9 frozen");
    endtask

    // R11: reset during the refresh run clears and restarts.
    task automatic t_reset_midway();
        rst_n = 1'b0;
        cfg_mrs_first = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (S + TRP + 2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sd_cs_n && !init_done, "R11", "pins after mid reset",
            {sd_cs_n, init_done}, 2'b10);
        do_run(1'b1, 3'b010, 1'b0, 3'b110, 1'b0, 1'b0);
        compare(1'b1, 3'b010, 1'b0, 3'b110, 1'b0, "R11 restart");
    endtask

    initial begin
        t_normal_order();
        t_mrs_first();
        t_cfg_frozen();
        t_reset_midway();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule